// File: doc/BRIEF.md
# DMA Bus Hold Arbiter

This block decides who owns a shared bus: a processor or a DMA engine. When the DMA engine raises its request, the arbiter raises a hold request. It then watches the processor's three bus status lines. Only when they show an idle (passive) bus cycle does it grant the hold. While it grants the bus, it drives an address-enable output that lets the DMA engine put addresses on the bus. It also keeps the processor's ready line low, so the processor cannot start another access.

The DMA engine ends a transfer by dropping its request. The arbiter then withdraws the hold request. One clock later it drops the grant and address-enable, and on the next clock it releases ready. External wait inputs, active low and asynchronous, are each synchronized first. They are then combined and registered to produce ready, so a slow device can still stretch processor cycles. The request input is asynchronous and is synchronized the same way.

The block has no data flow, so it has no valid/ready channel and applies no back-pressure. All pins are plain control levels. The processor status lines are taken as synchronous to the arbiter clock.

Top module: `dma_hold_arbiter`

## Requirements
- R1: While reset is asserted and right after it, hold_req, hold_ack and addr_en are 0 and cpu_ready is 1.
- R2: A rise of dma_req shows on hold_req SYNC_STAGES+1 rising clock edges later, counting the edge that first samples it. With the default of 2 stages this is the third edge.
- R3: hold_ack rises only on the edge after a cycle in which hold_req was 1 and cpu_status was 3'b111 (passive). While the status is anything else, the grant stays withheld.
- R4: addr_en is 1 in exactly the cycles in which hold_ack is 1.
- R5: cpu_ready is 0 from one edge after hold_req rises until one edge after addr_en falls. In particular it is 0 in every cycle where addr_en is 1.
- R6: A fall of dma_req during a grant clears hold_req SYNC_STAGES+1 edges later. hold_ack and addr_en clear one edge after that, and cpu_ready returns to 1 on the edge after that, provided no wait input is low.
- R7: Each bit of wait_n is active low. If any bit is 0, cpu_ready is 0 SYNC_STAGES+1 edges later. When all bits are 1 again and no transfer is pending, cpu_ready returns to 1 with the same latency.
- R8: If the request drops before the grant, hold_req clears and hold_ack never rises.
- R9: A request that comes back during the release is not granted at once. It gets hold_ack again only after a fresh passive status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_req | input | 1 | Asynchronous DMA request, active high |
| cpu_status | input | 3 | Processor bus status; 3'b111 means passive |
| wait_n | input | N_WAIT | Asynchronous wait inputs, active low |
| hold_req | output | 1 | Hold request toward the processor side |
| hold_ack | output | 1 | Hold grant to the DMA engine |
| addr_en | output | 1 | DMA address enable, high during the transfer |
| cpu_ready | output | 1 | Processor ready, low halts the processor |

## Verification
The bench builds the block with SYNC_STAGES = 2 and N_WAIT = 3. With these values the request path takes three edges to reach hold_req, and three independent wait lines can stall or release ready in overlapping patterns. Both latencies are short enough that directed checks can step through every edge of a grant and its release. Random runs also reach the cases where a request disappears while the arbiter is still waiting for passive status, or comes back during the one-cycle release window.

// File: rtl/dha_pkg.sv
package dha_pkg;

  localparam logic [2:0] PASSIVE_STATUS = 3'b111;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ASK  = 2'd1,
    ST_OWN  = 2'd2,
    ST_DROP = 2'd3
  } hold_state_t;

endpackage

// File: rtl/dha_sync.sv
module dha_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{{W{RST_VAL}}}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/dha_hold_fsm.sv
module dha_hold_fsm
  import dha_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_s,
  input  logic [2:0] cpu_status,
  output logic       hold_req,
  output logic       hold_ack
);

  hold_state_t state, state_nx;
  logic        passive;

  assign passive = (cpu_status == PASSIVE_STATUS);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (req_s) state_nx = ST_ASK;
      ST_ASK: begin
        if (!req_s)       state_nx = ST_IDLE;
        else if (passive) state_nx = ST_OWN;
      end
      ST_OWN:  if (!req_s) state_nx = ST_DROP;
      ST_DROP: state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign hold_req = (state == ST_ASK) || (state == ST_OWN);
  assign hold_ack = (state == ST_OWN) || (state == ST_DROP);

  // R3: a grant starts only after a passive status was seen
  a_r3_grant_after_passive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> ($past(cpu_status) == PASSIVE_STATUS));

  // R3: a grant is always preceded by a pending hold request
  a_r3_grant_after_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> $past(hold_req));

  // R6: once the request is withdrawn, the grant ends on the next edge
  a_r6_ack_trails_req: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && !hold_req) |=> !hold_ack);

  // R8: without a synchronized request nothing new is asked for
  a_r8_no_req_no_ask: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_s && !hold_req) |=> !hold_req);

endmodule

// File: rtl/dha_ready_gen.sv
module dha_ready_gen #(
  parameter int N_WAIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_WAIT-1:0] wait_s,
  input  logic              hold_req,
  input  logic              addr_en,
  output logic              cpu_ready
);

  logic waits_clear;
  logic bus_taken;

  assign waits_clear = &wait_s;
  assign bus_taken   = hold_req | addr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_ready <= 1'b1;
    else        cpu_ready <= waits_clear && !bus_taken;
  end

  // R6: ready is not left low once the transfer has ended and waits are clear
  a_r6_ready_released: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(addr_en) && waits_clear) |=> cpu_ready);

  // R7: any active wait stalls the processor on the next edge
  a_r7_wait_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    !waits_clear |=> !cpu_ready);

endmodule

// File: rtl/dma_hold_arbiter.sv
module dma_hold_arbiter #(
  parameter int SYNC_STAGES = 2,
  parameter int N_WAIT      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_req,
  input  logic [2:0]        cpu_status,
  input  logic [N_WAIT-1:0] wait_n,
  output logic              hold_req,
  output logic              hold_ack,
  output logic              addr_en,
  output logic              cpu_ready
);

  logic              req_s;
  logic [N_WAIT-1:0] wait_s;

  dha_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (dma_req),
    .q     (req_s)
  );

  dha_sync #(.W(N_WAIT), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wait_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (wait_n),
    .q     (wait_s)
  );

  dha_hold_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_s      (req_s),
    .cpu_status (cpu_status),
    .hold_req   (hold_req),
    .hold_ack   (hold_ack)
  );

  assign addr_en = hold_ack;

  dha_ready_gen #(.N_WAIT(N_WAIT)) u_ready (
    .clk       (clk),
    .rst_n     (rst_n),
    .wait_s    (wait_s),
    .hold_req  (hold_req),
    .addr_en   (addr_en),
    .cpu_ready (cpu_ready)
  );

  // R5: the processor is halted throughout the DMA transfer
  a_r5_ready_low_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    addr_en |-> !cpu_ready);

  // R5: a fresh hold request stalls the processor on the next edge
  a_r5_stall_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_req) |=> !cpu_ready);

endmodule

// File: tb/test_dma_hold_arbiter.sv
`timescale 1ns/1ps
module test_dma_hold_arbiter;

  localparam int SYNC = 2;
  localparam int NW   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dma_req = 1'b0;
  logic [2:0]    cpu_status = 3'b000;
  logic [NW-1:0] wait_n = '1;
  logic          hold_req, hold_ack, addr_en, cpu_ready;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dma_hold_arbiter #(.SYNC_STAGES(SYNC), .N_WAIT(NW)) i_dma_hold_arbiter (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .cpu_status(cpu_status),
    .wait_n(wait_n), .hold_req(hold_req), .hold_ack(hold_ack),
    .addr_en(addr_en), .cpu_ready(cpu_ready)
  );

  // reference model built from the requirements
  logic [SYNC-1:0]         m_rq;
  logic [SYNC-1:0][NW-1:0] m_w;
  int                      m_st;
  logic                    m_rdy;

  function automatic logic exp_req(int st);
    return (st == 1) || (st == 2);
  endfunction

  function automatic logic exp_ack(int st);
    return (st == 2) || (st == 3);
  endfunction

  function automatic int next_st(int st, logic rq, logic [2:0] stat);
    case (st)
      0: return rq ? 1 : 0;
      1: return !rq ? 0 : ((stat == 3'b111) ? 2 : 1);
      2: return rq ? 2 : 3;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rq <= '0; m_w <= '1; m_st <= 0; m_rdy <= 1'b1;
    end else begin
      m_rdy <= (&m_w[SYNC-1]) && !(exp_req(m_st) || exp_ack(m_st));
      m_st  <= next_st(m_st, m_rq[SYNC-1], cpu_status);
      m_rq  <= {m_rq[SYNC-2:0], dma_req};
      m_w   <= {m_w[SYNC-2:0], wait_n};
    end
  end

  task automatic chk(input logic act, input logic exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(hold_req,  exp_req(m_st), "R2 model hold_req");
      chk(hold_ack,  exp_ack(m_st), "R3 model hold_ack");
      chk(addr_en,   exp_ack(m_st), "R4 model addr_en");
      chk(cpu_ready, m_rdy,         "R5 model cpu_ready");
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_main();
    // R1 reset state
    step(3);
    chk(hold_req, 1'b0, "R1 hold_req in reset");
    chk(hold_ack, 1'b0, "R1 hold_ack in reset");
    chk(addr_en,  1'b0, "R1 addr_en in reset");
    chk(cpu_ready, 1'b1, "R1 cpu_ready in reset");
    rst_n = 1'b1;
    step(2);
    chk(cpu_ready, 1'b1, "R1 cpu_ready after reset");

    // R2 latency, R3 withheld grant
    dma_req = 1'b1;
    step(2); chk(hold_req, 1'b0, "R2 hold_req before latency");
    step(1); chk(hold_req, 1'b1, "R2 hold_req at latency");
    step(5); chk(hold_ack, 1'b0, "R3 no grant while busy status");
    chk(cpu_ready, 1'b0, "R5 stalled while asking");
    cpu_status = 3'b111;
    step(1); chk(hold_ack, 1'b1, "R3 grant after passive");
    chk(addr_en, 1'b1, "R4 addr_en with grant");
    cpu_status = 3'b010;
    step(4); chk(hold_ack, 1'b1, "R3 grant kept during transfer");
    chk(cpu_ready, 1'b0, "R5 ready low in transfer");

    // R6 release order
    dma_req = 1'b0;
    step(3); chk(hold_req, 1'b0, "R6 hold_req dropped");
    chk(hold_ack, 1'b1, "R6 grant one edge longer");
    step(1); chk(hold_ack, 1'b0, "R6 grant dropped");
    chk(addr_en, 1'b0, "R6 addr_en dropped");
    chk(cpu_ready, 1'b0, "R6 ready still low");
    step(1); chk(cpu_ready, 1'b1, "R6 ready released");

    // R8 abandoned request
    cpu_status = 3'b000;
    dma_req = 1'b1;
    step(4); chk(hold_req, 1'b1, "R8 asking");
    dma_req = 1'b0;
    step(4); chk(hold_req, 1'b0, "R8 request withdrawn");
    chk(hold_ack, 1'b0, "R8 never granted");
    step(2);

    // R9 request back during release
    cpu_status = 3'b111;
    dma_req = 1'b1;
    step(4); chk(hold_ack, 1'b1, "R9 first grant");
    cpu_status = 3'b100;
    dma_req = 1'b0;
    step(1);
    dma_req = 1'b1;
    step(8); chk(hold_req, 1'b1, "R9 asking again");
    chk(hold_ack, 1'b0, "R9 no grant without passive");
    cpu_status = 3'b111;
    step(1); chk(hold_ack, 1'b1, "R9 grant after passive");
    dma_req = 1'b0;
    step(8);

    // R7 wait inputs
    wait_n = 3'b101;
    step(2); chk(cpu_ready, 1'b1, "R7 ready before wait latency");
    step(1); chk(cpu_ready, 1'b0, "R7 wait stalls");
    wait_n = 3'b111;
    step(2); chk(cpu_ready, 1'b0, "R7 still stalled");
    step(1); chk(cpu_ready, 1'b1, "R7 wait released");

    // constrained random phase, checked by the model
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      if ($urandom_range(0, 15) == 0) dma_req = ~dma_req;
      cpu_status = ($urandom_range(0, 3) == 0) ? 3'b111 : 3'($urandom_range(0, 6));
      for (int b = 0; b < NW; b++) begin
        wait_n[b] = ($urandom_range(0, 19) != 0);
      end
    end
    dma_req = 1'b0;
    wait_n = '1;
    step(10);
    chk(hold_req, 1'b0, "R6 idle at end");
    chk(cpu_ready, 1'b1, "R6 ready at end");
  endtask

  initial begin
    void'($urandom(32'd1234));
    fork
      run_main();
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule